// File: doc/BRIEF.md
# Precision Time Event Frame Classifier

This block sits on a received Ethernet byte stream and decides, while the header is still arriving, whether the current frame carries a precision time protocol event message that needs a receive timestamp. It raises a single-cycle capture strobe for such a frame. A timestamp unit nearby uses that strobe to latch the free-running time value.

The decision depends on a programmed mode:
- **Off:** nothing is stamped.
- **Version-1:** only UDP-carried messages of one selected kind are stamped, either Sync or Delay_Req.
- **Version-2 event:** event messages are stamped whether they arrive directly over Ethernet or inside UDP.
- **All frames:** every frame is stamped.

For UDP-carried traffic, a separate enable adds a check of the source port.

The parser follows one optional 802.1Q tag, a variable-length IPv4 header and the UDP header. It uses a single down-counter to skip to each field it needs. The strobe is issued the cycle after the byte that settles the decision has been accepted.

Top module: `ptp_event_classifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `capStrobe` is low, whatever the stream inputs carry.
- R2: With `cfgMode`=3 (all frames), `capStrobe` pulses in the cycle after every accepted first byte (`inSof`=1).
- R3: With `cfgMode`=0 (off), `capStrobe` never pulses.
- R4: With `cfgMode`=2, a frame is stamped when all of these hold:
  - the big-endian EtherType at bytes 12-13 is 0x88F7, or it is at bytes 16-17 when bytes 12-13 hold the single tag type 0x8100;
  - the low nibble of the first payload byte (the message type) is 0 to 3.
- R5: A frame is accepted as UDP when all of these hold:
  - the EtherType is 0x0800;
  - the first IP byte has version nibble 4 (upper) and an IHL nibble of at least 5 (lower);
  - IP header byte 9 equals 17;
  - the big-endian destination port at UDP bytes 2-3 equals 319.
  The time message starts 8 bytes after the UDP header start, and the UDP header starts IHL*4 bytes into the IP header.
- R6: With `cfgSrcPortChk`=1, the UDP source port at UDP bytes 0-1 must also equal 319. With it low, the source port has no effect.
- R7: With `cfgMode`=1, only UDP frames per R5 are stamped, and only when time-message byte 32 equals `cfgV1Sel` (0 = Sync, 1 = Delay_Req). Frames carried directly over Ethernet are never stamped in this mode.
- R8: With `cfgMode`=2, a UDP frame per R5 is stamped when the low nibble of time-message byte 0 is 0 to 3. The upper nibble is ignored.
- R9: A stamped frame gives exactly one single-cycle pulse. The pulse comes in the cycle after the deciding byte is accepted:
  - byte 0 in mode 3;
  - message byte 0 in mode 2;
  - message byte 32 in mode 1.
- R10: No pulse is issued in any of these cases:
  - the frame ends (`inEof`) before its deciding byte;
  - the frame carries a second 0x8100 tag;
  - the EtherType is any other value;
  - the IP version is not 4, or the IHL is below 5;
  - the IP protocol is not 17.
- R11: Cycles with `inValid` low do not advance the parse, so idle gaps inside a frame do not change the result or the deciding byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte on `inData` is accepted this cycle |
| inSof | input | 1 | Accepted byte is the first of a frame |
| inEof | input | 1 | Accepted byte is the last of a frame |
| inData | input | 8 | Frame byte, destination address first |
| cfgMode | input | 2 | 0 off, 1 version-1 UDP, 2 version-2 event, 3 all frames |
| cfgV1Sel | input | 1 | Version-1 message kind: 0 Sync, 1 Delay_Req |
| cfgSrcPortChk | input | 1 | Also require UDP source port 319 |
| capStrobe | output | 1 | One-cycle capture pulse for a matching frame |

## Verification
The bench builds the block with its default parameters: port 319, EtherType 0x88F7, and the version-1 control byte at message offset 32. The skip counter is then wide enough for IHL values up to 15.

It sweeps every combination of the following, and computes the expected pulse and its deciding byte index from the frame layout:
- mode, tag presence and payload kind;
- source-port enable and version-1 selector;
- three message types and three port patterns.

Directed frames cover a 60-byte IP header, a bad version, a short IHL, a double tag, and truncation exactly before and on the deciding byte.

// File: rtl/ptpcls_pkg.sv
package ptpcls_pkg;

  localparam int CNT_W = 7;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_V1_UDP   = 2'd1,
    MODE_V2_EVENT = 2'd2,
    MODE_ALL      = 2'd3
  } mode_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic             loadCnt;
    logic [CNT_W-1:0] cntValue;
    logic             decCnt;
    logic             loadIhl;
    logic             setVlan;
    logic             clearVlan;
  } dpCtrl_t;

  // field comparisons from the datapath back to control
  typedef struct packed {
    logic             cntZero;
    logic             vlanSeen;
    logic             isVlan;
    logic             isPtpType;
    logic             isIpType;
    logic             isIpv4Ver;
    logic             ihlOk;
    logic             isUdp;
    logic             isEventPort;
    logic             isV2Event;
    logic             isV1Match;
    logic [CNT_W-1:0] udpSkip;
  } dpCmp_t;

endpackage

// File: rtl/ptpcls_datapath.sv
module ptpcls_datapath
  import ptpcls_pkg::*;
#(
  parameter logic [15:0] VLAN_ETYPE     = 16'h8100,
  parameter logic [15:0] PTP_ETYPE      = 16'h88F7,
  parameter logic [15:0] IPV4_ETYPE     = 16'h0800,
  parameter logic [7:0]  UDP_PROTO      = 8'd17,
  parameter logic [15:0] EVENT_PORT     = 16'd319,
  parameter int          IP_PROTO_OFS   = 9,
  parameter int          MIN_IHL        = 5,
  parameter int          V2_EVENT_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       cfgV1Sel,
  input  dpCtrl_t    ctrl,
  output dpCmp_t     cmp
);

  localparam int IHL_SHIFT = 2;

  logic [CNT_W-1:0] cnt;
  logic [7:0]       prevByte;
  logic [3:0]       ihl;
  logic             vlanSeen;
  logic [15:0]      word;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      prevByte <= '0;
      ihl      <= '0;
      vlanSeen <= 1'b0;
    end else begin
      if (inValid) prevByte <= inData;
      if (ctrl.loadCnt)     cnt <= ctrl.cntValue;
      else if (ctrl.decCnt) cnt <= cnt - 1'b1;
      if (ctrl.loadIhl) ihl <= inData[3:0];
      if (ctrl.clearVlan)    vlanSeen <= 1'b0;
      else if (ctrl.setVlan) vlanSeen <= 1'b1;
    end
  end

  assign word = {prevByte, inData};

  always_comb begin
    cmp.cntZero     = (cnt == '0);
    cmp.vlanSeen    = vlanSeen;
    cmp.isVlan      = (word == VLAN_ETYPE);
    cmp.isPtpType   = (word == PTP_ETYPE);
    cmp.isIpType    = (word == IPV4_ETYPE);
    cmp.isIpv4Ver   = (inData[7:4] == 4'd4);
    cmp.ihlOk       = (int'(inData[3:0]) >= MIN_IHL);
    cmp.isUdp       = (inData == UDP_PROTO);
    cmp.isEventPort = (word == EVENT_PORT);
    cmp.isV2Event   = (int'(inData[3:0]) < V2_EVENT_LIMIT);
    cmp.isV1Match   = (inData == {7'd0, cfgV1Sel});
    cmp.udpSkip     = CNT_W'({ihl, {IHL_SHIFT{1'b0}}}) - CNT_W'(IP_PROTO_OFS);
  end

  // R11: control never counts past zero
  cnt_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.decCnt |-> !cmp.cntZero);

  // R11: skip counter holds during idle cycles
  cnt_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !ctrl.loadCnt) |=> $stable(cnt));

endmodule

// File: rtl/ptpcls_control.sv
module ptpcls_control
  import ptpcls_pkg::*;
#(
  parameter int MAC_BYTES      = 6,
  parameter int TAG_BYTES      = 4,
  parameter int IP_PROTO_OFS   = 9,
  parameter int UDP_HDR_BYTES  = 8,
  parameter int V1_CTRL_OFS    = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  input  logic [1:0] cfgMode,
  input  logic       cfgSrcPortChk,
  input  dpCmp_t     cmp,
  output dpCtrl_t    ctrl,
  output logic       capStrobe
);

  localparam int ETYPE_SKIP    = 2 * MAC_BYTES;
  localparam int TAG_SKIP      = TAG_BYTES - 1;
  localparam int PROTO_SKIP    = IP_PROTO_OFS - 1;
  localparam int DST_SKIP      = 1;
  localparam int UDP_TAIL_SKIP = UDP_HDR_BYTES - 4;
  localparam int V1_SKIP       = UDP_TAIL_SKIP + V1_CTRL_OFS;

  typedef enum logic [2:0] {
    S_IDLE, S_ETYPE, S_IPVER, S_IPPROTO, S_UDPSRC, S_UDPDST, S_PTP
  } state_e;

  state_e state, stateNext;
  mode_e  mode;
  logic   hit;
  logic   frameFired;

  assign mode = mode_e'(cfgMode);

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    hit       = 1'b0;
    if (inValid) begin
      if (inSof) begin
        ctrl.clearVlan = 1'b1;
        stateNext      = S_IDLE;
        if (mode == MODE_ALL) begin
          hit = 1'b1;
        end else if (mode != MODE_OFF) begin
          stateNext     = S_ETYPE;
          ctrl.loadCnt  = 1'b1;
          ctrl.cntValue = CNT_W'(ETYPE_SKIP);
        end
      end else if (state != S_IDLE) begin
        if (!cmp.cntZero) begin
          ctrl.decCnt = 1'b1;
        end else begin
          ctrl.loadCnt = 1'b1;
          unique case (state)
            S_ETYPE: begin
              if (cmp.isVlan && !cmp.vlanSeen) begin
                ctrl.setVlan  = 1'b1;
                ctrl.cntValue = CNT_W'(TAG_SKIP);
              end else if (cmp.isPtpType && mode == MODE_V2_EVENT) begin
                stateNext = S_PTP;
              end else if (cmp.isIpType) begin
                stateNext = S_IPVER;
              end else begin
                stateNext = S_IDLE;
              end
            end
            S_IPVER: begin
              if (cmp.isIpv4Ver && cmp.ihlOk) begin
                ctrl.loadIhl  = 1'b1;
                ctrl.cntValue = CNT_W'(PROTO_SKIP);
                stateNext     = S_IPPROTO;
              end else begin
                stateNext = S_IDLE;
              end
            end
            S_IPPROTO: begin
              ctrl.cntValue = cmp.udpSkip;
              stateNext     = cmp.isUdp ? S_UDPSRC : S_IDLE;
            end
            S_UDPSRC: begin
              ctrl.cntValue = CNT_W'(DST_SKIP);
              stateNext     = (!cfgSrcPortChk || cmp.isEventPort) ? S_UDPDST : S_IDLE;
            end
            S_UDPDST: begin
              ctrl.cntValue = (mode == MODE_V1_UDP) ? CNT_W'(V1_SKIP) : CNT_W'(UDP_TAIL_SKIP);
              stateNext     = cmp.isEventPort ? S_PTP : S_IDLE;
            end
            S_PTP: begin
              hit       = (mode == MODE_V1_UDP) ? cmp.isV1Match :
                          (mode == MODE_V2_EVENT) ? cmp.isV2Event : 1'b0;
              stateNext = S_IDLE;
            end
            default: stateNext = S_IDLE;
          endcase
        end
      end
      if (inEof) stateNext = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      capStrobe <= 1'b0;
    end else begin
      state     <= stateNext;
      capStrobe <= hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  frameFired <= 1'b0;
    else if (inValid && inSof)  frameFired <= 1'b0;
    else if (capStrobe)         frameFired <= 1'b1;
  end

  // R9
  one_per_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |-> !frameFired);

  // R9
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |-> $past(inValid));

  // R2
  all_mode_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && cfgMode == 2'd3) |=> capStrobe);

  // R3
  off_mode_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cfgMode == 2'd0) |=> !capStrobe);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(state));

endmodule

// File: rtl/ptp_event_classifier.sv
module ptp_event_classifier
  import ptpcls_pkg::*;
#(
  parameter logic [15:0] PTP_ETYPE    = 16'h88F7,
  parameter logic [15:0] EVENT_PORT   = 16'd319,
  parameter int          V1_CTRL_OFS  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  input  logic [7:0] inData,
  input  logic [1:0] cfgMode,
  input  logic       cfgV1Sel,
  input  logic       cfgSrcPortChk,
  output logic       capStrobe
);

  localparam int IP_PROTO_OFS = 9;

  dpCtrl_t ctrl;
  dpCmp_t  cmp;

  ptpcls_datapath #(
    .VLAN_ETYPE     (16'h8100),
    .PTP_ETYPE      (PTP_ETYPE),
    .IPV4_ETYPE     (16'h0800),
    .UDP_PROTO      (8'd17),
    .EVENT_PORT     (EVENT_PORT),
    .IP_PROTO_OFS   (IP_PROTO_OFS),
    .MIN_IHL        (5),
    .V2_EVENT_LIMIT (4)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .cfgV1Sel (cfgV1Sel),
    .ctrl     (ctrl),
    .cmp      (cmp)
  );

  ptpcls_control #(
    .MAC_BYTES     (6),
    .TAG_BYTES     (4),
    .IP_PROTO_OFS  (IP_PROTO_OFS),
    .UDP_HDR_BYTES (8),
    .V1_CTRL_OFS   (V1_CTRL_OFS)
  ) i_control (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .inSof         (inSof),
    .inEof         (inEof),
    .cfgMode       (cfgMode),
    .cfgSrcPortChk (cfgSrcPortChk),
    .cmp           (cmp),
    .ctrl          (ctrl),
    .capStrobe     (capStrobe)
  );

endmodule

// File: tb/test_ptp_event_classifier.sv
module test_ptp_event_classifier;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid, inSof, inEof;
  logic [7:0] inData;
  logic [1:0] cfgMode;
  logic       cfgV1Sel, cfgSrcPortChk;
  logic       capStrobe;

  always #10 clk = ~clk;

  ptp_event_classifier i_ptp_event_classifier (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .cfgMode(cfgMode), .cfgV1Sel(cfgV1Sel),
    .cfgSrcPortChk(cfgSrcPortChk), .capStrobe(capStrobe)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] frm [0:255];
  int frmLen, ptpOfs;
  int strobeCnt, strobeIdx, prevDriven;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 direct PTP, 1 IPv4/UDP, 2 other EtherType, 3 IPv4/TCP
  task automatic buildFrame(input int vlan, input int kind, input int ihl, input int ver,
                            input int srcPort, input int dstPort, input int msg,
                            input int secondTag);
    int pos, udp;
    for (int i = 0; i < 256; i++) frm[i] = 8'h00;
    for (int i = 0; i < 12; i++) frm[i] = 8'hA0 + 8'(i);
    pos = 12;
    if (vlan != 0) begin
      frm[pos] = 8'h81; frm[pos+1] = 8'h00; frm[pos+2] = 8'h00; frm[pos+3] = 8'h05;
      pos += 4;
    end
    if (secondTag != 0) begin
      frm[pos] = 8'h81; frm[pos+1] = 8'h00; frm[pos+2] = 8'h00; frm[pos+3] = 8'h07;
      pos += 4;
    end
    case (kind)
      0:       begin frm[pos] = 8'h88; frm[pos+1] = 8'hF7; end
      2:       begin frm[pos] = 8'h86; frm[pos+1] = 8'hDD; end
      default: begin frm[pos] = 8'h08; frm[pos+1] = 8'h00; end
    endcase
    pos += 2;
    if (kind == 0) begin
      ptpOfs = pos;
    end else begin
      frm[pos]   = {4'(ver), 4'(ihl)};
      frm[pos+9] = (kind == 3) ? 8'd6 : 8'd17;
      udp = pos + ihl * 4;
      frm[udp]   = 8'(srcPort >> 8); frm[udp+1] = 8'(srcPort);
      frm[udp+2] = 8'(dstPort >> 8); frm[udp+3] = 8'(dstPort);
      ptpOfs = udp + 8;
    end
    frm[ptpOfs]    = 8'h10 | 8'(msg);
    frm[ptpOfs+32] = 8'(msg);
    frmLen = ptpOfs + 44;
  endtask

  task automatic sampleOut();
    if (capStrobe) begin
      strobeCnt++;
      strobeIdx = prevDriven;
    end
  endtask

  task automatic sendFrame(input bit gaps);
    strobeCnt = 0; strobeIdx = -1; prevDriven = -1;
    for (int i = 0; i < frmLen; i++) begin
      @(negedge clk); sampleOut();
      if (gaps && (i % 5 == 2)) begin
        inValid = 1'b0; prevDriven = -1;
        @(negedge clk); sampleOut();
      end
      inValid = 1'b1; inSof = (i == 0); inEof = (i == frmLen - 1); inData = frm[i];
      prevDriven = i;
    end
    @(negedge clk); sampleOut();
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; prevDriven = -1;
    @(negedge clk); sampleOut();
  endtask

  // expected result computed from the requirement rules
  task automatic runCase(input int mode, input int vlan, input int kind, input int ihl,
                         input int ver, input int src, input int dst, input int msg,
                         input int secondTag, input int srcChk, input int v1Sel,
                         input int lenOverride, input bit gaps, input string req);
    bit expHit, udpOk, l2Ok;
    int expIdx;
    buildFrame(vlan, kind, ihl, ver, src, dst, msg, secondTag);
    if (lenOverride > 0) frmLen = lenOverride;
    cfgMode = 2'(mode); cfgSrcPortChk = srcChk[0]; cfgV1Sel = v1Sel[0];
    l2Ok  = (kind == 0) && (secondTag == 0);
    udpOk = (kind == 1) && (secondTag == 0) && (ver == 4) && (ihl >= 5) && (dst == 319)
            && (srcChk == 0 || src == 319);
    expIdx = 0;
    case (mode)
      3: begin expHit = 1; expIdx = 0; end
      2: begin expHit = (l2Ok || udpOk) && (msg < 4); expIdx = ptpOfs; end
      1: begin expHit = udpOk && (msg == v1Sel); expIdx = ptpOfs + 32; end
      default: expHit = 0;
    endcase
    if (expHit && frmLen <= expIdx) expHit = 0;
    sendFrame(gaps);
    chk(strobeCnt == int'(expHit), req, strobeCnt, int'(expHit));
    if (expHit) chk(strobeIdx == expIdx, "R9", strobeIdx, expIdx);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int msgs [3] = '{0, 1, 4};
    int n;
    string req;
    rstN = 1'b0; inValid = 1'b1; inSof = 1'b1; inEof = 1'b0; inData = 8'h00;
    cfgMode = 2'd3; cfgV1Sel = 1'b0; cfgSrcPortChk = 1'b0;
    repeat (3) @(negedge clk);
    chk(capStrobe == 1'b0, "R1", int'(capStrobe), 0);
    inValid = 1'b0; inSof = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk(capStrobe == 1'b0, "R1", int'(capStrobe), 0);

    n = 0;
    for (int mode = 0; mode < 4; mode++)
      for (int vlan = 0; vlan < 2; vlan++)
        for (int kind = 0; kind < 4; kind++)
          for (int sc = 0; sc < 2; sc++)
            for (int vs = 0; vs < 2; vs++)
              for (int mi = 0; mi < 3; mi++)
                for (int pc = 0; pc < ((kind == 1) ? 3 : 1); pc++) begin
                  if (mode == 0) req = "R3";
                  else if (mode == 3) req = "R2";
                  else if (kind == 0) req = (mode == 1) ? "R7" : "R4";
                  else if (kind != 1) req = "R10";
                  else if (pc == 1) req = "R6";
                  else if (pc == 2) req = "R5";
                  else req = (mode == 1) ? "R7" : "R8";
                  if (n % 4 == 1) req = {req, "/R11"};
                  runCase(mode, vlan, kind, 5 + vlan, 4,
                          (pc == 1) ? 320 : 319, (pc == 2) ? 320 : 319, msgs[mi],
                          0, sc, vs, 0, (n % 4 == 1), req);
                  n++;
                end

    // R5: longest IP header
    runCase(1, 0, 1, 15, 4, 319, 319, 1, 0, 1, 1, 0, 0, "R5");
    runCase(2, 1, 1, 15, 4, 319, 319, 3, 0, 0, 0, 0, 1, "R5");
    // R10: bad version, short header, protocol, double tag
    runCase(2, 0, 1, 5, 6, 319, 319, 0, 0, 0, 0, 0, 0, "R10");
    runCase(1, 0, 1, 4, 4, 319, 319, 0, 0, 0, 0, 0, 0, "R10");
    runCase(2, 1, 0, 5, 4, 319, 319, 0, 1, 0, 0, 0, 0, "R10");
    runCase(2, 1, 1, 5, 4, 319, 319, 0, 1, 0, 0, 0, 0, "R10");
    // R10/R9: truncation just before and on the deciding byte
    buildFrame(0, 1, 5, 4, 319, 319, 1, 0);
    runCase(1, 0, 1, 5, 4, 319, 319, 1, 0, 0, 1, ptpOfs + 32, 0, "R10");
    runCase(1, 0, 1, 5, 4, 319, 319, 1, 0, 0, 1, ptpOfs + 33, 0, "R9");
    buildFrame(0, 0, 5, 4, 0, 0, 2, 0);
    runCase(2, 0, 0, 5, 4, 0, 0, 2, 0, 0, 0, ptpOfs, 1, "R10");
    runCase(2, 0, 0, 5, 4, 0, 0, 2, 0, 0, 0, ptpOfs + 1, 1, "R9");
    // R2: one-byte frames
    runCase(3, 0, 2, 5, 4, 0, 0, 0, 0, 0, 0, 1, 0, "R2");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule